// File: doc/BRIEF.md
# Stride Reference Prediction Table

The block watches the stream of memory instructions issued by a core. Each observation carries the program counter of a load or store and the effective address it touched. The block keeps a small fully associative table, keyed by program counter. Each entry remembers the last address that instruction used, the address step it last saw, and a confidence state. When an instruction's step has been seen twice in a row, the block emits a prefetch request for the address one step ahead of the current access.

Confidence moves through three states. A fresh entry starts as initial. It becomes transient once a first step has been measured. It becomes steady when the next step repeats. A mismatch in steady throws the entry back to initial. A mismatch in transient simply retrains the step. Replacement is least recently used, so recently active instructions keep their history. The request and the prefetch are both single-cycle strobes, and the prefetch appears one clock after the request that caused it.

Top module: `stride_rpt`

## Requirements
- R1: While reset is high, and in the cycle after it, `pf_vld` is low.
- R2: The first access by a PC with no table entry allocates an entry with step zero in the initial state, and it produces no prefetch.
- R3: The second access by a PC stores the difference between the current and the previous address as the step and moves the entry to transient, with no prefetch.
- R4: In transient, an access whose difference equals the stored step moves the entry to steady. In the clock after the request it raises `pf_vld` with `pf_addr` = current address + step.
- R5: In steady, every access whose difference equals the step raises `pf_vld` one clock later with `pf_addr` = current address + step.
- R6: In steady, an access whose difference differs from the step produces no prefetch and returns the entry to initial. The next access re-learns the step without a prefetch, and the access after that prefetches if the step holds.
- R7: In transient, an access whose difference differs from the step produces no prefetch, stores the new difference as the step and stays in transient, so the following matching access prefetches.
- R8: An entry whose step is zero never produces a prefetch, even when steady.
- R9: The table holds `ENTRIES` (default 64) PCs. A PC stays resident while fewer than `ENTRIES` other PCs have been accessed since its last access. Otherwise it has been evicted by least recently used replacement, and its next access behaves as in R2.
- R10: Entries of different PCs are independent, so interleaved streams, including negative steps in two's complement, are each tracked correctly.
- R11: `pf_vld` is high only in the clock directly after a cycle with `req_vld` high. The previous address is updated on every access, whatever the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | An access is observed this cycle |
| req_pc | input | PC_W | Program counter of the memory instruction |
| req_addr | input | ADDR_W | Effective address of the access |
| pf_vld | output | 1 | Prefetch request strobe, registered |
| pf_addr | output | ADDR_W | Prefetch address, valid with `pf_vld` |

## Verification
Checks run on every cycle guard the following:
- A prefetch only follows a request by one clock, and it only follows a table hit.
- A prefetch address never equals the triggering address, since the step is never zero.
- No PC ever matches two entries.
- The entry just touched is never the next victim.

Only the bench's scenarios can show the rest:
- the state sequence initial, transient, steady, and the two mismatch paths;
- the exact prefetch address, including negative steps;
- eviction after exactly `ENTRIES` other PCs.

// File: rtl/stride_rpt_pkg.sv
`timescale 1ns/1ps
package stride_rpt_pkg;
  typedef enum logic [1:0] {
    ST_INIT   = 2'd0,
    ST_TRANS  = 2'd1,
    ST_STEADY = 2'd2
  } rpt_state_e;
endpackage

// File: rtl/rpt_lookup.sv
`timescale 1ns/1ps
module rpt_lookup #(
  parameter int ENTRIES = 64,
  parameter int PC_W    = 32,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] ent_vld,
  input  logic [PC_W-1:0]    ent_tag [ENTRIES],
  input  logic [PC_W-1:0]    pc,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [ENTRIES-1:0] hit_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = ent_vld[g] && (ent_tag[g] == pc);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_idx = IDX_W'(i);
  end

  assign hit = |hit_vec;

  // R9
  single_match_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

// File: rtl/rpt_lru.sv
`timescale 1ns/1ps
module rpt_lru #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [IDX_W-1:0] victim_idx
);
  localparam logic [IDX_W-1:0] AGE_MAX = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] age_q [ENTRIES];
  logic [IDX_W-1:0] touched_age;

  assign touched_age = age_q[touch_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touch_idx)      age_q[i] <= '0;
        else if (age_q[i] < touched_age) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (age_q[i] == AGE_MAX) victim_idx = IDX_W'(i);
  end

  // R9
  fresh_not_victim_chk: assert property (@(posedge clk) disable iff (rst)
    touch |=> (victim_idx != $past(touch_idx)));
endmodule

// File: rtl/rpt_predict.sv
`timescale 1ns/1ps
module rpt_predict
  import stride_rpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  rpt_state_e        cur_state,
  input  logic [ADDR_W-1:0] cur_stride,
  input  logic [ADDR_W-1:0] prev_addr,
  input  logic [ADDR_W-1:0] addr,
  output rpt_state_e        nxt_state,
  output logic [ADDR_W-1:0] nxt_stride,
  output logic              fire,
  output logic [ADDR_W-1:0] target
);
  logic [ADDR_W-1:0] delta;
  logic              same;

  assign delta  = addr - prev_addr;
  assign same   = (delta == cur_stride);
  assign target = addr + cur_stride;

  always_comb begin
    nxt_state  = cur_state;
    nxt_stride = cur_stride;
    fire       = 1'b0;
    unique case (cur_state)
      ST_INIT: begin
        nxt_stride = delta;
        nxt_state  = ST_TRANS;
      end
      ST_TRANS: begin
        if (same) begin
          nxt_state = ST_STEADY;
          fire      = (cur_stride != '0);
        end else begin
          nxt_stride = delta;
        end
      end
      ST_STEADY: begin
        if (same) fire = (cur_stride != '0);
        else      nxt_state = ST_INIT;
      end
      default: nxt_state = ST_INIT;
    endcase
  end
endmodule

// File: rtl/stride_rpt.sv
`timescale 1ns/1ps
module stride_rpt
  import stride_rpt_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int PC_W    = 32,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld,
  input  logic [PC_W-1:0]   req_pc,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              pf_vld,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld_q;
  logic [PC_W-1:0]    tag_q    [ENTRIES];
  logic [ADDR_W-1:0]  prev_q   [ENTRIES];
  logic [ADDR_W-1:0]  stride_q [ENTRIES];
  rpt_state_e         state_q  [ENTRIES];

  logic               hit;
  logic [IDX_W-1:0]   hit_idx, victim_idx, wr_idx;
  logic [ENTRIES-1:0] hit_vec;
  rpt_state_e         nxt_state;
  logic [ADDR_W-1:0]  nxt_stride, target;
  logic               fire;

  rpt_lookup #(.ENTRIES(ENTRIES), .PC_W(PC_W), .IDX_W(IDX_W)) u_lookup (
    .clk(clk), .rst(rst), .ent_vld(vld_q), .ent_tag(tag_q), .pc(req_pc),
    .hit(hit), .hit_idx(hit_idx), .hit_vec(hit_vec)
  );

  rpt_lru #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst(rst), .touch(req_vld), .touch_idx(wr_idx),
    .victim_idx(victim_idx)
  );

  rpt_predict #(.ADDR_W(ADDR_W)) u_predict (
    .cur_state(state_q[hit_idx]), .cur_stride(stride_q[hit_idx]),
    .prev_addr(prev_q[hit_idx]), .addr(req_addr),
    .nxt_state(nxt_state), .nxt_stride(nxt_stride),
    .fire(fire), .target(target)
  );

  assign wr_idx = hit ? hit_idx : victim_idx;

  // Table body: no reset, single write port per cycle.
  always_ff @(posedge clk) begin
    if (req_vld) begin
      tag_q[wr_idx]  <= req_pc;
      prev_q[wr_idx] <= req_addr;
      if (hit) begin
        stride_q[wr_idx] <= nxt_stride;
        state_q[wr_idx]  <= nxt_state;
      end else begin
        stride_q[wr_idx] <= '0;
        state_q[wr_idx]  <= ST_INIT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q   <= '0;
      pf_vld  <= 1'b0;
      pf_addr <= '0;
    end else begin
      if (req_vld) vld_q[wr_idx] <= 1'b1;
      pf_vld  <= req_vld && hit && fire;
      pf_addr <= target;
    end
  end

  // R11
  pf_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    pf_vld |-> $past(req_vld));

  // R2
  pf_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    pf_vld |-> $past(hit));

  // R8
  pf_nonzero_step_chk: assert property (@(posedge clk) disable iff (rst)
    pf_vld |-> (pf_addr != $past(req_addr)));
endmodule

// File: tb/stride_rpt_tb.sv
`timescale 1ns/1ps
module stride_rpt_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_vld = 1'b0;
  logic [31:0] req_pc = '0;
  logic [31:0] req_addr = '0;
  logic        pf_vld;
  logic [31:0] pf_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit took   = 1'b0;

  logic        exp_v [$];
  logic [31:0] exp_a [$];
  string       exp_r [$];

  always #5 clk = ~clk;

  stride_rpt u_dut (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_pc(req_pc),
    .req_addr(req_addr), .pf_vld(pf_vld), .pf_addr(pf_addr)
  );

  task automatic send(input logic [31:0] pc, input logic [31:0] addr,
                      input logic ev, input logic [31:0] ea, input string r);
    @(negedge clk);
    req_vld  = 1'b1;
    req_pc   = pc;
    req_addr = addr;
    exp_v.push_back(ev);
    exp_a.push_back(ea);
    exp_r.push_back(r);
  endtask

  task automatic idle();
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  always @(posedge clk) took <= req_vld && !rst;

  // Monitor: compares each result against the scoreboard queue.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (took) begin
        logic        ev;
        logic [31:0] ea;
        string       r;
        ev = exp_v.pop_front();
        ea = exp_a.pop_front();
        r  = exp_r.pop_front();
        checks++;
        if (pf_vld !== ev || (ev && pf_addr !== ea)) begin
          fails++;
          $display("FAIL %s: pf_vld=%0b pf_addr=%h expected pf_vld=%0b pf_addr=%h",
                   r, pf_vld, pf_addr, ev, ea);
        end
      end else if (pf_vld !== 1'b0) begin
        checks++;
        fails++;
        $display("FAIL R11: pf_vld=%0b with no request, expected 0", pf_vld);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (pf_vld !== 1'b0) begin
      fails++;
      $display("FAIL R1: pf_vld=%0b during reset, expected 0", pf_vld);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (pf_vld !== 1'b0) begin
      fails++;
      $display("FAIL R1: pf_vld=%0b after reset, expected 0", pf_vld);
    end

    // R2 R3 R4 R5: steady stream of step 4
    send(32'h100, 32'd100, 0, 0, "R2 first access");
    send(32'h100, 32'd104, 0, 0, "R3 learn step");
    send(32'h100, 32'd108, 1, 32'd112, "R4 confirm step");
    send(32'h100, 32'd112, 1, 32'd116, "R5 steady");
    // R6: break in steady, relearn
    send(32'h100, 32'd200, 0, 0, "R6 steady mismatch");
    send(32'h100, 32'd204, 0, 0, "R6 relearn");
    send(32'h100, 32'd208, 1, 32'd212, "R6 reconfirm");
    idle();

    // R7: transient mismatch retrains
    send(32'h200, 32'd0,  0, 0, "R7 alloc");
    send(32'h200, 32'd10, 0, 0, "R7 learn 10");
    send(32'h200, 32'd30, 0, 0, "R7 retrain 20");
    send(32'h200, 32'd50, 1, 32'd70, "R7 new step");
    idle();

    // R8: zero step
    send(32'h300, 32'd5, 0, 0, "R8 alloc");
    send(32'h300, 32'd5, 0, 0, "R8 learn zero");
    send(32'h300, 32'd5, 0, 0, "R8 confirm zero");
    send(32'h300, 32'd5, 0, 0, "R8 steady zero");
    idle();

    // R10: interleaved streams, one with a negative step
    send(32'h400, 32'd1000, 0, 0, "R10 A alloc");
    send(32'h500, 32'd5000, 0, 0, "R10 B alloc");
    send(32'h400, 32'd1008, 0, 0, "R10 A learn");
    send(32'h500, 32'd4996, 0, 0, "R10 B learn");
    send(32'h400, 32'd1016, 1, 32'd1024, "R10 A confirm");
    send(32'h500, 32'd4992, 1, 32'd4988, "R10 B confirm");
    send(32'h400, 32'd1024, 1, 32'd1032, "R10 A steady");
    send(32'h500, 32'd4988, 1, 32'd4984, "R10 B steady");
    idle();

    // R9: LRU residency and eviction
    send(32'h9000_0000, 32'd0,  0, 0, "R9 train alloc");
    send(32'h9000_0000, 32'd16, 0, 0, "R9 train learn");
    send(32'h9000_0000, 32'd32, 1, 32'd48, "R9 train confirm");
    for (int i = 0; i < 63; i++)
      send(32'hA000_0000 + 32'(i), 32'(i * 64), 0, 0, "R9 filler A");
    send(32'h9000_0000, 32'd48, 1, 32'd64, "R9 resident after 63 others");
    for (int i = 0; i < 64; i++)
      send(32'hB000_0000 + 32'(i), 32'(i * 64), 0, 0, "R9 filler B");
    send(32'h9000_0000, 32'd64, 0, 0, "R9 evicted after 64 others");
    send(32'h9000_0000, 32'd80, 0, 0, "R9 reallocated learns");
    send(32'h9000_0000, 32'd96, 1, 32'd112, "R9 reallocated confirms");
    idle();

    repeat (4) @(negedge clk);
    checks++;
    if (exp_v.size() != 0) begin
      fails++;
      $display("FAIL R11: %0d results missing, expected 0", exp_v.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule